// File: doc/BRIEF.md
# Chopper Gate Controller with Minimum Off-Time

This block drives the gate of the switch that chops current through one stepper motor winding. Two comparator flags arrive from outside, both asynchronous to the block clock. The high flag reads 1 while the sensed winding current is below the upper threshold, which is about 1.6 V at the sense point. The low flag reads 1 while the current is below the lower threshold, which is about 0.3 V. The block turns the gate on when the current drops under the lower limit and turns it off when the current rises over the upper limit. When the current sits between the two limits, the gate keeps its value.

The switching rate of a plain hysteretic chopper climbs with the supply voltage. To cap it, every turn-off starts a blanking interval of `BLANK_CYC` clock cycles, for example 10 µs times the clock frequency. The blanking timer cannot be retriggered. While it runs, no turn-on is accepted. Turn-on is judged on the level of the flags, so a current still under the lower limit when blanking ends turns the gate on at once. An over-limit current still forces the gate off at any time.

A status output shows when blanking is active. A wrapping counter of completed on-off periods lets the switching rate be measured.

Top module: `chop_gate_ctrl`

## Requirements
- R1: Each flag passes through a two-flop synchroniser. A flag pair first sampled at rising edge k can change `gate_o` no earlier and no later than edge k+2.
- R2: When the synchronised flags differ, `gate_o` keeps its value. Differing flags means high=1 with low=0 (inside the band), or the inconsistent pair high=0 with low=1.
- R3: When both synchronised flags are 0 (current above the upper limit), `gate_o` is 0 on the next edge, whatever the blanking state.
- R4: When both synchronised flags are 1 (current below the lower limit), `gate_o` becomes 1 on the next edge, but only if blanking is inactive. While blanking is active the gate stays 0, so each off period lasts at least BLANK_CYC+1 cycles.
- R5: Every 1-to-0 transition of `gate_o` starts blanking. `blank_o` is 1 for exactly BLANK_CYC cycles, starting in the cycle in which `gate_o` first reads 0.
- R6: Blanking cannot be retriggered. Flag activity during the interval, including over-limit and in-band patterns, neither extends it nor restarts it.
- R7: Turn-on is level-qualified. If both flags stay 1 through blanking, `gate_o` reads 1 in the cycle right after the first cycle with `blank_o` at 0.
- R8: `period_cnt_o` increases by one on each 1-to-0 transition of `gate_o` and wraps modulo 2^CNT_W.
- R9: A synchronous active-high reset clears the gate, the blanking timer, the period count and the synchroniser flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| below_hi_i | input | 1 | Asynchronous flag, 1 = current below upper threshold |
| below_lo_i | input | 1 | Asynchronous flag, 1 = current below lower threshold |
| gate_o | output | 1 | Switch gate command, 1 = on |
| blank_o | output | 1 | Minimum off-time interval running |
| period_cnt_o | output | CNT_W | Wrapping count of completed on-off periods |

## Verification
Three regimes are tried:
- A slow current ramp, where the off time is longer than blanking. This shows that pure hysteresis behaves as before.
- A fast rise followed by a long under-limit hold. This shows the timer setting the turn-on instant.
- A burst of mixed flag pairs during blanking. This separates a non-retriggerable timer from one that restarts on activity.

The inconsistent flag pair and a reset in the middle of blanking show that hold and reset take priority over any pending turn-on. A long run of fast periods exercises the wrap of the period counter.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ZN_INSIDE  = 2'd0,
    ZN_ABOVE   = 2'd1,
    ZN_BELOW   = 2'd2,
    ZN_INVALID = 2'd3
  } zone_t;

  // Map the flag pair onto the current zone.
  function automatic zone_t classify(input logic below_hi, input logic below_lo);
    zone_t z;
    case ({below_hi, below_lo})
      2'b00:   z = ZN_ABOVE;
      2'b11:   z = ZN_BELOW;
      2'b10:   z = ZN_INSIDE;
      default: z = ZN_INVALID;
    endcase
    return z;
  endfunction

  // Next gate value from the zone, the blanking state and the present gate.
  function automatic logic gate_next(input zone_t z, input logic blanking, input logic gate);
    logic g;
    case (z)
      ZN_ABOVE: g = 1'b0;
      ZN_BELOW: g = blanking ? gate : 1'b1;
      default:  g = gate;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic meta_q;
      logic sync_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
        end else begin
          meta_q <= d_i[gi];
          sync_q <= meta_q;
        end
      end
      assign q_o[gi] = sync_q;
    end
  endgenerate

endmodule

// File: rtl/chop_gate_fsm.sv
module chop_gate_fsm
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hi_s_i,
  input  logic lo_s_i,
  input  logic blank_i,
  output logic gate_o,
  output logic turn_off_o
);

  zone_t zone;
  logic  gate_q;
  logic  gate_d;

  assign zone       = classify(hi_s_i, lo_s_i);
  assign gate_d     = gate_next(zone, blank_i, gate_q);
  assign turn_off_o = gate_q & ~gate_d;
  assign gate_o     = gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_d;
  end

  a_r2_hold_in_band: assert property (@(posedge clk) disable iff (rst)
    (zone == ZN_INSIDE || zone == ZN_INVALID) |=> $stable(gate_q));

  a_r3_over_limit_off: assert property (@(posedge clk) disable iff (rst)
    (zone == ZN_ABOVE) |=> !gate_q);

  a_r4_blank_blocks_on: assert property (@(posedge clk) disable iff (rst)
    (blank_i && !gate_q) |=> !gate_q);

  a_r7_level_turn_on: assert property (@(posedge clk) disable iff (rst)
    (zone == ZN_BELOW && !blank_i) |=> gate_q);

endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
  parameter int BLANK_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic blank_o
);

  localparam int TW = $clog2(BLANK_CYC + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(BLANK_CYC);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] c, input logic ld);
    logic [TW-1:0] n;
    if (ld)             n = LOAD_VAL;
    else if (c != '0)   n = c - 1'b1;
    else                n = '0;
    return n;
  endfunction

  assign cnt_d   = step(cnt_q, load_i);
  assign blank_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  a_r5_full_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == LOAD_VAL));

  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !load_i);

  a_r6_steady_count: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/chop_period_cnt.sv
module chop_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (inc_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> (count_q == $past(count_q) + 1'b1));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(count_q));

endmodule

// File: rtl/chop_gate_ctrl.sv
module chop_gate_ctrl #(
  parameter int BLANK_CYC = 2500,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             below_hi_i,
  input  logic             below_lo_i,
  output logic             gate_o,
  output logic             blank_o,
  output logic [CNT_W-1:0] period_cnt_o
);

  logic [1:0] flags_s;
  logic       hi_s;
  logic       lo_s;
  logic       turn_off;
  logic       blanking;
  logic       gate;

  chop_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({below_hi_i, below_lo_i}),
    .q_o (flags_s)
  );

  assign hi_s = flags_s[1];
  assign lo_s = flags_s[0];

  chop_gate_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hi_s_i     (hi_s),
    .lo_s_i     (lo_s),
    .blank_i    (blanking),
    .gate_o     (gate),
    .turn_off_o (turn_off)
  );

  chop_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load_i  (turn_off),
    .blank_o (blanking)
  );

  chop_period_cnt #(.CNT_W(CNT_W)) u_periods (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (turn_off),
    .count_o (period_cnt_o)
  );

  assign gate_o  = gate;
  assign blank_o = blanking;

  a_r5_fall_starts_blank: assert property (@(posedge clk) disable iff (rst)
    $fell(gate) |-> blanking);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!gate && !blanking && period_cnt_o == '0));

endmodule

// File: tb/chop_gate_ctrl_tb.sv
`timescale 1ns/1ps
module chop_gate_ctrl_tb;

  localparam int B  = 50;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi  = 1'b0;
  logic lo  = 1'b0;
  logic gate;
  logic blank;
  logic [CW-1:0] per;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #2 clk = ~clk;

  chop_gate_ctrl #(.BLANK_CYC(B), .CNT_W(CW)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .below_hi_i   (hi),
    .below_lo_i   (lo),
    .gate_o       (gate),
    .blank_o      (blank),
    .period_cnt_o (per)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: delay line of flag pairs, gate, remaining blank time, periods.
  int fq[$];
  int m_gate, m_left, m_per;

  initial begin
    fq = '{0, 0};
    m_gate = 0; m_left = 0; m_per = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      fq = '{0, 0};
      m_gate = 0; m_left = 0; m_per = 0;
    end else begin
      int pair, ng;
      pair = fq.pop_front();
      fq.push_back({30'd0, hi, lo});
      ng = m_gate;
      if (pair == 0) ng = 0;
      else if (pair == 3 && m_left == 0) ng = 1;
      if (m_gate == 1 && ng == 0) begin
        m_left = B;
        m_per  = (m_per + 1) % (1 << CW);
      end else if (m_left > 0) begin
        m_left = m_left - 1;
      end
      m_gate = ng;
    end
  end

  // Per-cycle comparison and port-level timing monitors.
  int blank_run = 0;
  int off_run   = 0;
  bit seen_fall = 0;
  int falls     = 0;
  logic prev_gate = 1'b0;

  always @(negedge clk) begin
    if (!finished) begin
      check("R1 R2 R3 R4 gate", int'(gate), m_gate);
      check("R5 R6 blank", int'(blank), (m_left > 0) ? 1 : 0);
      check("R8 period count", int'(per), m_per);
      if (rst) begin
        blank_run = 0; off_run = 0; seen_fall = 0; falls = 0;
      end else begin
        if (blank) blank_run++;
        else if (blank_run > 0) begin
          check("R5 R6 blank length", blank_run, B);
          blank_run = 0;
        end
        if (prev_gate && !gate) begin
          seen_fall = 1; off_run = 0; falls++;
        end
        if (!gate) off_run++;
        if (!prev_gate && gate && seen_fall)
          check("R4 min off time", (off_run >= B + 1) ? 1 : 0, 1);
      end
      prev_gate = gate;
    end
  end

  task automatic hold(input logic h, input logic l, input int n);
    @(negedge clk);
    hi = h; lo = l;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset gate", int'(gate), 0);
    check("R9 reset blank", int'(blank), 0);
    check("R9 reset count", int'(per), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R9 initial gate", int'(gate), 0);
    check("R9 initial count", int'(per), 0);

    // R1 latency: pair presented after a negedge, first sampled at next edge.
    hold(1'b1, 1'b0, 4);
    @(negedge clk); hi = 1'b1; lo = 1'b1;
    @(negedge clk); check("R1 not yet after edge k", int'(gate), 0);
    @(negedge clk); check("R1 not yet after edge k+1", int'(gate), 0);
    @(negedge clk); check("R1 on after edge k+2", int'(gate), 1);

    // Slow ramp: off time exceeds blanking.
    for (int i = 0; i < 5; i++) begin
      hold(1'b1, 1'b1, 10);
      hold(1'b1, 1'b0, 30);
      hold(1'b0, 1'b0, 5);
      hold(1'b1, 1'b0, 80);
    end

    // R2: inconsistent pair while on holds the gate.
    hold(1'b1, 1'b1, 6);
    hold(1'b0, 1'b1, 12);
    check("R2 invalid pair holds on", int'(gate), 1);
    hold(1'b1, 1'b0, 12);
    check("R2 in band holds on", int'(gate), 1);

    // R7: fast rise, then held under the lower limit through blanking.
    hold(1'b0, 1'b0, 2);
    hold(1'b1, 1'b1, 1);
    while (!blank) @(negedge clk);
    while (blank) @(negedge clk);
    check("R7 still off at first unblanked cycle", int'(gate), 0);
    @(negedge clk);
    check("R7 on right after blanking", int'(gate), 1);

    // R6: mixed activity during blanking does not extend it.
    hold(1'b0, 1'b0, 2);
    for (int i = 0; i < 5; i++) begin
      hold(1'b1, 1'b0, 3);
      hold(1'b0, 1'b0, 3);
      hold(1'b0, 1'b1, 3);
      hold(1'b1, 1'b1, 3);
    end
    hold(1'b1, 1'b1, B + 10);
    check("R6 on after unextended blanking", int'(gate), 1);

    // R8 wrap: many fast periods.
    for (int i = 0; i < 20; i++) begin
      hold(1'b0, 1'b0, 3);
      hold(1'b1, 1'b1, B + 8);
    end
    check("R8 wrapped period count", int'(per), falls % (1 << CW));

    // R9: reset in the middle of blanking.
    hold(1'b0, 1'b0, 6);
    check("R5 blanking running before reset", int'(blank), 1);
    do_reset();
    hold(1'b1, 1'b1, 6);
    check("R9 on after reset without waiting", int'(gate), 1);
    hold(1'b1, 1'b0, 4);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule